// File: doc/BRIEF.md
# Four-Step Instruction Sequencer

This block is the control sequencer of a small multi-cycle integer core. A step counter walks every instruction through four steps, 0 to 3. From the step value, the opcode class of the current instruction word and a few handshake inputs, one combinational decoder raises several groups of control lines at once. These are register-file port selects, an ALU enable with its function code, and a bus request with its address source, access kind and size. There are also three strobes: one captures a fetched word into a prefetch holder, one moves that word into the instruction register, and one advances the program counter.

For register-register and register-immediate arithmetic, fetching the next word shares steps 0 and 1 with operand selection and ALU control. Loads and stores need the bus for their own data. For them the sequencer issues the data access first in step 1, then fetches the next word in step 2. Any bus step waits for the acknowledge. An interrupt request or a missing instruction word at step 0 keeps the sequencer idle. A synchronous reset request clears every output and sends the counter back to step 0.

The datapath, register file, trap logic and full legality decoding sit outside this block. It only emits the control lines.

Top module: `tseq_top`

## Requirements
- R1: While `seq_clr` is high every control output is 0, and on the next clock `step` is 0; after `rst_n` is released `step` is 0.
- R2: At step 0 with `irq` high or `instr_ok` low, every control output is 0 and `step` stays 0.
- R3: At step 0 with `irq` low and `instr_ok` high, `rf_sel` is 1 (first source), `rf_addr` is `iword[19:15]`, and `step` becomes 1.
- R4: In the R3 case, when the opcode `iword[6:0]` is neither 0000011 (load) nor 0100011 (store), a fetch is raised: `bus_req`=1, `bus_src`=0 (program counter), `bus_prog`=1, `bus_size`=2, `bus_we`=0.
- R5: A fetch at step 1 (non-memory opcodes) or step 2 (load/store) with `bus_ack` low keeps the request up and holds `step`; with `bus_ack` high, `pf_load` is 1 and `step` advances.
- R6: At step 1 for opcode 0110011 (register) or 0010011 (immediate): `alu_en`=1, `alu_fn`={`iword[30]` for register ops or for immediate ops with `iword[14:12]`=101, else 0; `iword[14:12]`}, `imm_sel`=1 only for immediate ops, and for register ops `rf_sel`=2 with `rf_addr`=`iword[24:20]`; a fetch (as in R4) is raised in the same cycle.
- R7: At step 2 for the two arithmetic opcodes: `rf_sel`=3, `rf_addr`=`iword[11:7]`, `rf_we`=1, no bus request, and `step` becomes 3.
- R8: For load/store there is no bus request at step 0; at step 1 a data access is raised (`bus_req`=1, `bus_src`=1, `bus_prog`=0, `bus_size`=`iword[13:12]`, `bus_we`=1 only for store) together with `alu_en`=1, `alu_fn`=0, `imm_sel`=1; a store also selects `rf_sel`=2 with `rf_addr`=`iword[24:20]`; `step` advances only on `bus_ack`.
- R9: At step 2 for load/store a fetch is raised as in R4, under the R5 stall rule.
- R10: At step 3 `pc_inc`=1 and `ir_load`=1, a load also sets `rf_sel`=3, `rf_addr`=`iword[11:7]`, `rf_we`=1, and `step` returns to 0.
- R11: Any other opcode fetches at steps 0 and 1 only, drives no ALU or register write at any step, passes step 2 in one cycle and ends as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| seq_clr | input | 1 | Synchronous reset request |
| irq | input | 1 | Pending interrupt request |
| instr_ok | input | 1 | Instruction register holds a valid word |
| iword | input | XLEN (32) | Current instruction register |
| bus_ack | input | 1 | Bus acknowledge |
| step | output | STEP_W (3) | Current step |
| rf_sel | output | 2 | Register port select: 0 none, 1 first source, 2 second source, 3 destination |
| rf_addr | output | RF_AW (5) | Register address taken from the selected field |
| rf_we | output | 1 | Register write enable |
| imm_sel | output | 1 | ALU second operand from immediate |
| alu_en | output | 1 | ALU operation enable |
| alu_fn | output | 4 | ALU function code |
| bus_req | output | 1 | Bus request |
| bus_src | output | 1 | Bus address source: 0 program counter, 1 ALU result |
| bus_prog | output | 1 | Program (instruction) access strobe |
| bus_size | output | 2 | Access size code |
| bus_we | output | 1 | Bus write |
| pf_load | output | 1 | Capture fetched word into prefetch holder |
| ir_load | output | 1 | Move prefetched word into instruction register |
| pc_inc | output | 1 | Advance program counter |

## Verification
The bench uses the default parameters: a three-bit step counter, 32-bit instruction words and five-bit register addresses. All four live steps are reachable with these values. The field positions the decoder slices are the ones the requirements name, and the opcode and size bits can be drawn at random across every class, including opcodes outside the four decoded ones. The three-bit counter also leaves step codes 4 to 7 as states the design must never enter, which the range property watches. Random acknowledge, interrupt and clear patterns cover stalls of any length at each bus step and clears in the middle of an instruction.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  // instruction word field positions
  localparam int OPC_W    = 7;
  localparam int RD_LSB   = 7;
  localparam int F3_LSB   = 12;
  localparam int F3_W     = 3;
  localparam int RS1_LSB  = 15;
  localparam int RS2_LSB  = 20;
  localparam int ALT_BIT  = 30;

  // opcode values
  localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;

  typedef enum logic [2:0] {
    IC_REG   = 3'd0,
    IC_IMM   = 3'd1,
    IC_LOAD  = 3'd2,
    IC_STORE = 3'd3,
    IC_MISC  = 3'd4
  } icls_e;

  typedef enum logic [1:0] {
    RF_NONE = 2'd0,
    RF_SRC1 = 2'd1,
    RF_SRC2 = 2'd2,
    RF_DEST = 2'd3
  } rfsel_e;

endpackage

// File: rtl/tseq_rst_sync.sv
module tseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tseq_class_dec.sv
module tseq_class_dec
  import tseq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output icls_e            cls,
  output logic             is_mem
);
  always_comb begin
    case (opcode)
      OPC_REG:   cls = IC_REG;
      OPC_IMM:   cls = IC_IMM;
      OPC_LOAD:  cls = IC_LOAD;
      OPC_STORE: cls = IC_STORE;
      default:   cls = IC_MISC;
    endcase
  end

  assign is_mem = (cls == IC_LOAD) || (cls == IC_STORE);
endmodule

// File: rtl/tseq_step_ctr.sv
module tseq_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_clr,
  input  logic              adv,
  input  logic              wrap,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] step_q, step_nxt;
  logic              step_en;

  always_comb begin
    step_en  = seq_clr | wrap | adv;
    step_nxt = step_q;
    if (seq_clr || wrap) step_nxt = '0;
    else if (adv)        step_nxt = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_nxt;
  end

  assign step = step_q;

  // R1
  clr_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> (step == '0));
endmodule

// File: rtl/tseq_ctl_dec.sv
module tseq_ctl_dec
  import tseq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int STEP_W   = 3,
  parameter int RF_AW    = 5,
  parameter int FN_W     = 4,
  parameter int SIZE_W   = 2,
  parameter int WORD_SZ  = 2
) (
  input  logic [STEP_W-1:0] step,
  input  icls_e             cls,
  input  logic              is_mem,
  input  logic [XLEN-1:0]   iword,
  input  logic              seq_clr,
  input  logic              irq,
  input  logic              instr_ok,
  input  logic              bus_ack,
  output rfsel_e            rf_sel,
  output logic [RF_AW-1:0]  rf_addr,
  output logic              rf_we,
  output logic              imm_sel,
  output logic              alu_en,
  output logic [FN_W-1:0]   alu_fn,
  output logic              bus_req,
  output logic              bus_src,
  output logic              bus_prog,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_we,
  output logic              pf_load,
  output logic              ir_load,
  output logic              pc_inc,
  output logic              adv,
  output logic              wrap
);
  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);

  logic [RF_AW-1:0] f_rs1, f_rs2, f_rd;
  logic [F3_W-1:0]  f_fn3;
  logic             alt_use;
  logic [FN_W-1:0]  arith_fn;

  assign f_rs1    = iword[RS1_LSB +: RF_AW];
  assign f_rs2    = iword[RS2_LSB +: RF_AW];
  assign f_rd     = iword[RD_LSB  +: RF_AW];
  assign f_fn3    = iword[F3_LSB  +: F3_W];
  assign alt_use  = (cls == IC_REG) || ((cls == IC_IMM) && (f_fn3 == 3'b101));
  assign arith_fn = FN_W'({iword[ALT_BIT] & alt_use, f_fn3});

  always_comb begin
    rf_sel   = RF_NONE;
    rf_addr  = '0;
    rf_we    = 1'b0;
    imm_sel  = 1'b0;
    alu_en   = 1'b0;
    alu_fn   = '0;
    bus_req  = 1'b0;
    bus_src  = 1'b0;
    bus_prog = 1'b0;
    bus_size = '0;
    bus_we   = 1'b0;
    pf_load  = 1'b0;
    ir_load  = 1'b0;
    pc_inc   = 1'b0;
    adv      = 1'b0;
    wrap     = 1'b0;
    if (!seq_clr) begin
      case (step)
        S0: begin
          if (!irq && instr_ok) begin
            rf_sel  = RF_SRC1;
            rf_addr = f_rs1;
            adv     = 1'b1;
            if (!is_mem) begin
              bus_req  = 1'b1;
              bus_prog = 1'b1;
              bus_size = SIZE_W'(WORD_SZ);
            end
          end
        end
        S1: begin
          if (is_mem) begin
            bus_req  = 1'b1;
            bus_src  = 1'b1;
            bus_size = iword[F3_LSB +: SIZE_W];
            bus_we   = (cls == IC_STORE);
            alu_en   = 1'b1;
            imm_sel  = 1'b1;
            if (cls == IC_STORE) begin
              rf_sel  = RF_SRC2;
              rf_addr = f_rs2;
            end
            adv = bus_ack;
          end else begin
            bus_req  = 1'b1;
            bus_prog = 1'b1;
            bus_size = SIZE_W'(WORD_SZ);
            pf_load  = bus_ack;
            adv      = bus_ack;
            if (cls != IC_MISC) begin
              alu_en  = 1'b1;
              alu_fn  = arith_fn;
              imm_sel = (cls == IC_IMM);
              if (cls == IC_REG) begin
                rf_sel  = RF_SRC2;
                rf_addr = f_rs2;
              end
            end
          end
        end
        S2: begin
          if (is_mem) begin
            bus_req  = 1'b1;
            bus_prog = 1'b1;
            bus_size = SIZE_W'(WORD_SZ);
            pf_load  = bus_ack;
            adv      = bus_ack;
          end else begin
            adv = 1'b1;
            if (cls != IC_MISC) begin
              rf_sel  = RF_DEST;
              rf_addr = f_rd;
              rf_we   = 1'b1;
            end
          end
        end
        S3: begin
          pc_inc  = 1'b1;
          ir_load = 1'b1;
          wrap    = 1'b1;
          if (cls == IC_LOAD) begin
            rf_sel  = RF_DEST;
            rf_addr = f_rd;
            rf_we   = 1'b1;
          end
        end
        default: wrap = 1'b1;
      endcase
    end
  end

  // R8
  data_never_prog_chk: assert final (!(bus_req && bus_src && bus_prog));
endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int STEP_W  = 3,
  parameter int RF_AW   = 5,
  parameter int FN_W    = 4,
  parameter int SIZE_W  = 2,
  parameter int WORD_SZ = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_clr,
  input  logic              irq,
  input  logic              instr_ok,
  input  logic [XLEN-1:0]   iword,
  input  logic              bus_ack,
  output logic [STEP_W-1:0] step,
  output logic [1:0]        rf_sel,
  output logic [RF_AW-1:0]  rf_addr,
  output logic              rf_we,
  output logic              imm_sel,
  output logic              alu_en,
  output logic [FN_W-1:0]   alu_fn,
  output logic              bus_req,
  output logic              bus_src,
  output logic              bus_prog,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_we,
  output logic              pf_load,
  output logic              ir_load,
  output logic              pc_inc
);
  localparam int LAST_STEP = 3;

  logic   rst_sync_n;
  icls_e  cls;
  rfsel_e rf_sel_e;
  logic   is_mem, adv, wrap;
  logic   unused_iword_bits;

  assign unused_iword_bits = ^{iword[XLEN-1:ALT_BIT+1], iword[ALT_BIT-1:RS2_LSB+RF_AW]};

  tseq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tseq_class_dec u_cls (
    .opcode(iword[OPC_W-1:0]), .cls(cls), .is_mem(is_mem)
  );

  tseq_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk(clk), .rst_n(rst_sync_n), .seq_clr(seq_clr),
    .adv(adv), .wrap(wrap), .step(step)
  );

  tseq_ctl_dec #(
    .XLEN(XLEN), .STEP_W(STEP_W), .RF_AW(RF_AW),
    .FN_W(FN_W), .SIZE_W(SIZE_W), .WORD_SZ(WORD_SZ)
  ) u_dec (
    .step(step), .cls(cls), .is_mem(is_mem), .iword(iword),
    .seq_clr(seq_clr), .irq(irq), .instr_ok(instr_ok), .bus_ack(bus_ack),
    .rf_sel(rf_sel_e), .rf_addr(rf_addr), .rf_we(rf_we), .imm_sel(imm_sel),
    .alu_en(alu_en), .alu_fn(alu_fn), .bus_req(bus_req), .bus_src(bus_src),
    .bus_prog(bus_prog), .bus_size(bus_size), .bus_we(bus_we),
    .pf_load(pf_load), .ir_load(ir_load), .pc_inc(pc_inc),
    .adv(adv), .wrap(wrap)
  );

  assign rf_sel = rf_sel_e;

  // R10
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step <= STEP_W'(LAST_STEP));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == '0 && (irq || !instr_ok)) |=> (step == '0));

  // R3
  start_adv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == '0 && !seq_clr && !irq && instr_ok) |=> (step == STEP_W'(1)));

  // R5
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_prog && !bus_ack && step != '0 && !seq_clr) |=> $stable(step));

  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ir_load && !seq_clr) |=> (step == '0));

  // R8
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !bus_prog) |-> (step == STEP_W'(1)));
endmodule

// File: tb/tseq_top_test.sv
module tseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n, seq_clr, irq, instr_ok, bus_ack;
  logic [31:0] iword;
  logic [2:0]  step;
  logic [1:0]  rf_sel, bus_size;
  logic [4:0]  rf_addr;
  logic [3:0]  alu_fn;
  logic        rf_we, imm_sel, alu_en, bus_req, bus_src, bus_prog, bus_we;
  logic        pf_load, ir_load, pc_inc;

  int errors = 0;
  int checks = 0;
  logic [2:0] mstep = 3'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tseq_top uut (
    .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .irq(irq), .instr_ok(instr_ok),
    .iword(iword), .bus_ack(bus_ack), .step(step), .rf_sel(rf_sel),
    .rf_addr(rf_addr), .rf_we(rf_we), .imm_sel(imm_sel), .alu_en(alu_en),
    .alu_fn(alu_fn), .bus_req(bus_req), .bus_src(bus_src), .bus_prog(bus_prog),
    .bus_size(bus_size), .bus_we(bus_we), .pf_load(pf_load), .ir_load(ir_load),
    .pc_inc(pc_inc)
  );

  // order: rf_sel rf_addr rf_we imm_sel alu_en alu_fn req src prog size we pf ir pc
  function automatic logic [22:0] exp_out(logic [2:0] st, logic [31:0] w,
                                           logic clr, logic iq, logic ok, logic ack);
    logic [1:0] sel = 0; logic [4:0] ad = 0; logic we_rf = 0, imm = 0, ae = 0;
    logic [3:0] fn = 0; logic rq = 0, src = 0, prg = 0, bw = 0, pf = 0, il = 0, pi = 0;
    logic [1:0] sz = 0;
    bit r = (w[6:0] == 7'b0110011), im = (w[6:0] == 7'b0010011);
    bit ld = (w[6:0] == 7'b0000011), stc = (w[6:0] == 7'b0100011);
    bit mem = ld || stc, ar = r || im;
    if (!clr) begin
      if (st == 0 && !iq && ok) begin
        sel = 1; ad = w[19:15];
        if (!mem) begin rq = 1; prg = 1; sz = 2; end
      end else if (st == 1 && mem) begin
        rq = 1; src = 1; sz = w[13:12]; bw = stc; ae = 1; imm = 1;
        if (stc) begin sel = 2; ad = w[24:20]; end
      end else if (st == 1) begin
        rq = 1; prg = 1; sz = 2; pf = ack;
        if (ar) begin
          ae = 1; imm = im;
          fn = {w[30] & (r || (w[14:12] == 3'b101)), w[14:12]};
          if (r) begin sel = 2; ad = w[24:20]; end
        end
      end else if (st == 2 && mem) begin
        rq = 1; prg = 1; sz = 2; pf = ack;
      end else if (st == 2 && ar) begin
        sel = 3; ad = w[11:7]; we_rf = 1;
      end else if (st == 3) begin
        pi = 1; il = 1;
        if (ld) begin sel = 3; ad = w[11:7]; we_rf = 1; end
      end
    end
    return {sel, ad, we_rf, imm, ae, fn, rq, src, prg, sz, bw, pf, il, pi};
  endfunction

  function automatic logic [2:0] nxt_step(logic [2:0] st, logic [31:0] w,
                                          logic clr, logic iq, logic ok, logic ack);
    bit mem = (w[6:0] == 7'b0000011) || (w[6:0] == 7'b0100011);
    if (clr) return 0;
    case (st)
      0: return (!iq && ok) ? 3'd1 : 3'd0;
      1: return ack ? 3'd2 : 3'd1;
      2: return (mem && !ack) ? 3'd2 : 3'd3;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] st, logic [31:0] w,
                                   logic clr, logic iq, logic ok, logic ack);
    bit mem = (w[6:0] == 7'b0000011) || (w[6:0] == 7'b0100011);
    bit ar = (w[6:0] == 7'b0110011) || (w[6:0] == 7'b0010011);
    if (clr) return "R1";
    if (st == 0) return (iq || !ok) ? "R2" : (mem ? "R3" : "R4");
    if (((st == 1 && !mem) || (st == 2 && mem)) && !ack) return "R5";
    if (st == 1) return mem ? "R8" : (ar ? "R6" : "R11");
    if (st == 2) return mem ? "R9" : (ar ? "R7" : "R11");
    return "R10";
  endfunction

  task automatic one_cycle(logic clr, logic iq, logic ok, logic ack, logic [31:0] w);
    logic [22:0] e, a;
    @(negedge clk);
    seq_clr = clr; irq = iq; instr_ok = ok; bus_ack = ack; iword = w;
    #1;
    e = exp_out(mstep, w, clr, iq, ok, ack);
    a = {rf_sel, rf_addr, rf_we, imm_sel, alu_en, alu_fn, bus_req, bus_src,
         bus_prog, bus_size, bus_we, pf_load, ir_load, pc_inc};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s outputs at step %0d: actual=%h expected=%h",
               req_of(mstep, w, clr, iq, ok, ack), mstep, a, e);
    end
    checks++;
    if (step !== mstep) begin
      errors++;
      $display("FAIL %s step: actual=%0d expected=%0d",
               req_of(mstep, w, clr, iq, ok, ack), step, mstep);
    end
    mstep = nxt_step(mstep, w, clr, iq, ok, ack);
  endtask

  function automatic logic [31:0] rand_word(int kind);
    logic [31:0] w = $urandom;
    case (kind)
      0: w[6:0] = 7'b0110011;
      1: w[6:0] = 7'b0010011;
      2: w[6:0] = 7'b0000011;
      3: w[6:0] = 7'b0100011;
      default: w[6:0] = 7'b1101111;
    endcase
    return w;
  endfunction

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EC0_0017));
    rst_n = 1'b0; seq_clr = 1'b1; irq = 1'b0; instr_ok = 1'b0; bus_ack = 1'b0;
    iword = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state with clear held
    repeat (3) one_cycle(1, 0, 1, 0, 32'h0000_0033);

    // R2: interrupt and missing word keep step 0
    one_cycle(0, 1, 1, 1, 32'h0000_0033);
    one_cycle(0, 0, 0, 1, 32'h0000_0033);

    // R4 R6 R5 R7 R10: register op with two stall cycles, alt bit set
    w = 32'h40C5_8233;
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 1, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 0, w);

    // R6: immediate shift right with alt bit
    w = 32'h4031_5093;
    repeat (4) one_cycle(0, 0, 1, 1, w);

    // R8 R9 R10: load with data stall then fetch stall
    w = 32'h0042_A303;
    one_cycle(0, 0, 1, 1, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 1, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(0, 0, 1, 1, w);
    one_cycle(0, 0, 1, 0, w);

    // R8: store, byte size
    w = 32'h00B5_0023;
    repeat (4) one_cycle(0, 0, 1, 1, w);

    // R11: other opcode
    w = 32'h0000_00EF;
    repeat (4) one_cycle(0, 0, 1, 1, w);

    // R1: clear mid-instruction
    w = 32'h0000_0033;
    one_cycle(0, 0, 1, 1, w);
    one_cycle(0, 0, 1, 0, w);
    one_cycle(1, 0, 1, 1, w);
    one_cycle(0, 1, 1, 1, w);

    // random mix
    w = rand_word(0);
    for (int i = 0; i < 3000; i++) begin
      if (mstep == 0) w = rand_word(int'($urandom_range(0, 4)));
      one_cycle(($urandom_range(0, 49) == 0), ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1, w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule